// File: doc/BRIEF.md
# Periodic and Alarm Interrupt Controller

This block sits beside a calendar time counter and turns its rollover strobes into a processor interrupt. The seven periodic strobes each last one cycle: tenth-second, second, minute, hour, day, week and month. An eighth source is the rising edge of a level match coming from an alarm comparator. Software writes a control byte that chooses which sources may interrupt. A status byte records every enabled source that has fired. A high-true interrupt line stays asserted while any recorded source is still enabled.

Software reads the status byte to find out why the interrupt fired. The status clears when the read access is removed, not when it starts, so the value on the bus stays steady for the whole access. An event that lands in the same cycle as the clear is kept. A second output, the standby interrupt, is active low. It follows the match level directly whenever its enable bit is set.

Top module: `periodic_alarm_irq`

## Requirements
- R1: After reset, the status, control and standby enable registers are zero, `irqOut` is 0 and `stbyIrqN` is 1.
- R2: A write to address 15h loads the control byte, and a read of address 15h returns it. Control bit i enables source i.
- R3: Source bits are ordered tenth-second at bit 0, second 1, minute 2, hour 3, day 4, week 5, month 6 and compare 7. A strobe on an enabled source sets its status bit at that clock edge. A strobe on a disabled source leaves status unchanged.
- R4: `irqOut` is registered. It is high one clock after a cycle in which some status bit and its control bit are both 1, and low otherwise.
- R5: A read of address 14h returns the status byte. At the first clock edge where a status read is no longer presented, status clears to zero, and `irqOut` falls one clock later.
- R6: A source event at the same edge where status clears is kept, and its status bit is 1 after that edge.
- R7: The compare bit sets only on a rising edge of `matchLvl`. A match level that stays high does not set the bit again after a clear.
- R8: Bit 0 of a write to address 16h sets or clears the standby enable, and a read of 16h returns it in bit 0. `stbyIrqN` is low exactly while the enable is 1 and `matchLvl` is 1. A match that is already present when the enable is written pulls the output low at once.
- R9: While a status read is held, no status bit clears.
- R10: Clearing a control bit masks that source's status from `irqOut` one clock later, but the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rollStrb | input | 7 | One-cycle rollover strobes, tenth-second at bit 0 through month at bit 6 |
| matchLvl | input | 1 | Alarm comparator match level |
| busAddr | input | 5 | Register address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read access, held for the length of the access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, zero when no register read is presented |
| irqOut | output | 1 | High-true main interrupt |
| stbyIrqN | output | 1 | Active-low standby interrupt |

## Verification
The bench builds the block with its default parameters: seven periodic sources plus the compare source, an 8-bit data bus and a 5-bit address. With these values every status bit maps onto the data byte, so a read of 14h shows the whole recorded state. Random strobes, match toggles, held reads and control rewrites then reach the cases where events coincide with a clear, and the cases where a mask changes while status is pending.

// File: rtl/pai_pkg.sv
package pai_pkg;
  typedef struct packed {
    logic wrCtrl;
    logic wrStby;
    logic selStat;
    logic selCtrl;
    logic selStby;
    logic rdEnd;
  } paiStrb_t;
endpackage

// File: rtl/pai_ctrl.sv
module pai_ctrl
  import pai_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 5'h14,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 5'h15,
  parameter logic [ADDR_W-1:0] STBY_ADDR   = 5'h16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output paiStrb_t          strb
);
  logic rdStatNow;
  logic rdStatQ;

  assign rdStatNow = busRd && (busAddr == STATUS_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) rdStatQ <= 1'b0;
    else       rdStatQ <= rdStatNow;
  end

  always_comb begin
    strb.wrCtrl  = busWr && (busAddr == CTRL_ADDR);
    strb.wrStby  = busWr && (busAddr == STBY_ADDR);
    strb.selStat = rdStatNow;
    strb.selCtrl = busRd && (busAddr == CTRL_ADDR);
    strb.selStby = busRd && (busAddr == STBY_ADDR);
    strb.rdEnd   = rdStatQ && !rdStatNow;
  end
endmodule

// File: rtl/pai_datapath.sv
module pai_datapath
  import pai_pkg::*;
#(
  parameter int NUM_PERIODIC = 7,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  paiStrb_t              strb,
  input  logic [NUM_PERIODIC-1:0] rollStrb,
  input  logic                  matchLvl,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  irqOut,
  output logic                  stbyIrqN,
  output logic [NUM_PERIODIC:0] status,
  output logic [NUM_PERIODIC:0] ctrlReg,
  output logic                  stbyEn
);
  localparam int NUM_SRC = NUM_PERIODIC + 1;

  logic               matchQ;
  logic [NUM_SRC-1:0] evt;
  logic [NUM_SRC-1:0] statusNext;

  assign evt = {matchLvl & ~matchQ, rollStrb};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign statusNext[i] = (evt[i] & ctrlReg[i]) | (status[i] & ~strb.rdEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchQ  <= 1'b0;
      status  <= '0;
      ctrlReg <= '0;
      stbyEn  <= 1'b0;
      irqOut  <= 1'b0;
    end else begin
      matchQ <= matchLvl;
      status <= statusNext;
      irqOut <= |(status & ctrlReg);
      if (strb.wrCtrl) ctrlReg <= busWdata[NUM_SRC-1:0];
      if (strb.wrStby) stbyEn  <= busWdata[0];
    end
  end

  assign stbyIrqN = ~(stbyEn & matchLvl);

  always_comb begin
    busRdata = '0;
    if (strb.selStat)      busRdata[NUM_SRC-1:0] = status;
    else if (strb.selCtrl) busRdata[NUM_SRC-1:0] = ctrlReg;
    else if (strb.selStby) busRdata[0] = stbyEn;
  end
endmodule

// File: rtl/periodic_alarm_irq.sv
module periodic_alarm_irq
  import pai_pkg::*;
#(
  parameter int NUM_PERIODIC = 7,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 5'h14,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 5'h15,
  parameter logic [ADDR_W-1:0] STBY_ADDR   = 5'h16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_PERIODIC-1:0] rollStrb,
  input  logic                    matchLvl,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWr,
  input  logic                    busRd,
  input  logic [DATA_W-1:0]       busWdata,
  output logic [DATA_W-1:0]       busRdata,
  output logic                    irqOut,
  output logic                    stbyIrqN
);
  paiStrb_t              strb;
  logic [NUM_PERIODIC:0] status;
  logic [NUM_PERIODIC:0] ctrlReg;
  logic                  stbyEn;

  pai_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR),
    .CTRL_ADDR(CTRL_ADDR), .STBY_ADDR(STBY_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .strb(strb)
  );

  pai_datapath #(.NUM_PERIODIC(NUM_PERIODIC), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rollStrb(rollStrb),
    .matchLvl(matchLvl), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .stbyIrqN(stbyIrqN), .status(status),
    .ctrlReg(ctrlReg), .stbyEn(stbyEn)
  );
endmodule

// File: rtl/pai_chk.sv
module pai_chk #(
  parameter int NUM_PERIODIC = 7,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h15
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_PERIODIC-1:0] rollStrb,
  input logic                    matchLvl,
  input logic [ADDR_W-1:0]       busAddr,
  input logic                    busWr,
  input logic [DATA_W-1:0]       busWdata,
  input logic                    irqOut,
  input logic                    stbyIrqN,
  input logic [NUM_PERIODIC:0]   status,
  input logic [NUM_PERIODIC:0]   ctrlReg,
  input logic                    stbyEn,
  input logic                    rdEnd
);
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == CTRL_ADDR) |=> ctrlReg == $past(busWdata[NUM_PERIODIC:0])); // R2
  AST_SRC_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (rollStrb[0] && ctrlReg[0]) |=> status[0]); // R3
  AST_CMP_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(matchLvl) && ctrlReg[NUM_PERIODIC]) |=> status[NUM_PERIODIC]); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|(status & ctrlReg))); // R4
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdEnd && !(|rollStrb) && !matchLvl) |=> status == '0); // R5
  AST_HOLD_READ: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEnd) |-> ((status & $past(status)) == $past(status))); // R9
  AST_STBY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (stbyEn && matchLvl) |-> !stbyIrqN); // R8
  AST_STBY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !stbyEn |-> stbyIrqN); // R8
endmodule

bind periodic_alarm_irq pai_chk #(
  .NUM_PERIODIC(NUM_PERIODIC), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .rollStrb(rollStrb), .matchLvl(matchLvl),
  .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
  .irqOut(irqOut), .stbyIrqN(stbyIrqN), .status(status),
  .ctrlReg(ctrlReg), .stbyEn(stbyEn), .rdEnd(strb.rdEnd)
);

// File: tb/tb_periodic_alarm_irq.sv
module tb_periodic_alarm_irq;
  logic       clk = 1'b0;
  logic       rstN;
  logic [6:0] rollStrb;
  logic       matchLvl;
  logic [4:0] busAddr;
  logic       busWr;
  logic       busRd;
  logic [7:0] busWdata;
  logic [7:0] busRdata;
  logic       irqOut;
  logic       stbyIrqN;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  // bench model state
  logic [7:0] mStat, mCtrl;
  logic mStby, mIrq, mPrevM, mPrevRd;

  always #2.5 clk = ~clk;

  periodic_alarm_irq dut (
    .clk(clk), .rstN(rstN), .rollStrb(rollStrb), .matchLvl(matchLvl),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .stbyIrqN(stbyIrqN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nextStat(input logic [7:0] st, input logic [7:0] ev,
                                          input logic [7:0] en, input logic clr);
    return clr ? (ev & en) : (st | (ev & en));
  endfunction

  // one clock: apply inputs after a falling edge, update model at the rising edge
  task automatic step(input logic [6:0] rs, input logic m, input logic wr,
                      input logic rd, input logic [4:0] a, input logic [7:0] wd);
    logic [7:0] ev;
    logic rdNow, newIrq;
    rollStrb = rs; matchLvl = m; busWr = wr; busRd = rd; busAddr = a; busWdata = wd;
    @(posedge clk);
    ev = {m & ~mPrevM, rs};
    rdNow = rd && (a == 5'h14);
    newIrq = |(mStat & mCtrl);
    mStat = nextStat(mStat, ev, mCtrl, mPrevRd && !rdNow);
    if (wr && a == 5'h15) mCtrl = wd;
    if (wr && a == 5'h16) mStby = wd[0];
    mIrq = newIrq; mPrevM = m; mPrevRd = rdNow;
    @(negedge clk);
  endtask

  task automatic idle(input logic m); step(7'd0, m, 0, 0, 5'h0, 8'h0); endtask
  task automatic rdReg(input logic m, input logic [4:0] a); step(7'd0, m, 0, 1, a, 8'h0); endtask
  task automatic wrReg(input logic m, input logic [4:0] a, input logic [7:0] d);
    step(7'd0, m, 1, 0, a, d);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    void'($urandom(32'd2718));
    rstN = 0; rollStrb = 0; matchLvl = 0; busAddr = 0; busWr = 0; busRd = 0; busWdata = 0;
    mStat = 0; mCtrl = 0; mStby = 0; mIrq = 0; mPrevM = 0; mPrevRd = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    check(irqOut == 0, "R1 irq", irqOut, 0);
    check(stbyIrqN == 1, "R1 stby", stbyIrqN, 1);
    rdReg(0, 5'h14); check(busRdata == 0, "R1 status", busRdata, 0);
    rdReg(0, 5'h15); check(busRdata == 0, "R1 ctrl", busRdata, 0);
    rdReg(0, 5'h16); check(busRdata == 0, "R1 stbyEn", busRdata, 0);
    idle(0);

    // R2 control write and readback
    wrReg(0, 5'h15, 8'h05);
    rdReg(0, 5'h15); check(busRdata == 8'h05, "R2 ctrl readback", busRdata, 8'h05);
    idle(0);

    // R3 disabled source (minute, bit 2 is enabled; second, bit 1 is not)
    step(7'h02, 0, 0, 0, 0, 0); idle(0);
    check(irqOut == 0, "R3 disabled irq", irqOut, 0);
    rdReg(0, 5'h14); check(busRdata == 0, "R3 disabled status", busRdata, 0);
    idle(0);

    // R3/R4 enabled minute source, interrupt timing
    step(7'h04, 0, 0, 0, 0, 0);
    check(irqOut == 0, "R4 irq not yet", irqOut, 0);
    idle(0);
    check(irqOut == 1, "R4 irq raised", irqOut, 1);
    rdReg(0, 5'h14); check(busRdata == 8'h04, "R3 minute at bit 2", busRdata, 8'h04);
    rdReg(0, 5'h14); check(busRdata == 8'h04, "R9 held read", busRdata, 8'h04);
    check(irqOut == 1, "R9 irq during read", irqOut, 1);
    idle(0);
    idle(0);
    check(irqOut == 0, "R5 irq cleared", irqOut, 0);
    rdReg(0, 5'h14); check(busRdata == 0, "R5 status cleared", busRdata, 0);
    idle(0);

    // R6 event at the clearing edge is kept
    rdReg(0, 5'h14);
    step(7'h01, 0, 0, 0, 0, 0);
    idle(0);
    check(irqOut == 1, "R6 irq kept", irqOut, 1);
    rdReg(0, 5'h14); check(busRdata == 8'h01, "R6 status kept", busRdata, 8'h01);
    idle(0); idle(0);

    // R7 compare rising edge only
    wrReg(0, 5'h15, 8'h80);
    idle(1);
    rdReg(1, 5'h14); check(busRdata == 8'h80, "R7 compare bit 7", busRdata, 8'h80);
    idle(1); idle(1); idle(1);
    check(irqOut == 0, "R7 held level no reset", irqOut, 0);
    rdReg(1, 5'h14); check(busRdata == 0, "R7 status stays clear", busRdata, 0);
    idle(0); idle(1);
    rdReg(1, 5'h14); check(busRdata == 8'h80, "R7 new rise", busRdata, 8'h80);
    idle(0); idle(0);

    // R8 standby follows level, asserts at once on an existing match
    idle(1);
    check(stbyIrqN == 1, "R8 disabled", stbyIrqN, 1);
    wrReg(1, 5'h16, 8'h01);
    check(stbyIrqN == 0, "R8 pre-matched", stbyIrqN, 0);
    idle(0); check(stbyIrqN == 1, "R8 follows low level", stbyIrqN, 1);
    idle(1); check(stbyIrqN == 0, "R8 follows high level", stbyIrqN, 0);
    rdReg(1, 5'h16); check(busRdata == 8'h01, "R8 readback", busRdata, 1);
    wrReg(1, 5'h16, 8'h00);
    check(stbyIrqN == 1, "R8 disabled again", stbyIrqN, 1);
    idle(0);
    rdReg(0, 5'h14); idle(0); idle(0);

    // R10 masking after status set
    wrReg(0, 5'h15, 8'h01);
    step(7'h01, 0, 0, 0, 0, 0); idle(0);
    check(irqOut == 1, "R10 before mask", irqOut, 1);
    wrReg(0, 5'h15, 8'h00);
    idle(0);
    check(irqOut == 0, "R10 masked", irqOut, 0);
    rdReg(0, 5'h14); check(busRdata == 8'h01, "R10 status kept", busRdata, 8'h01);
    idle(0);
    wrReg(0, 5'h15, 8'hFF); idle(0);

    // random mix checked against the model
    begin
      logic m = 0;
      logic rd = 0;
      for (int i = 0; i < 4000; i++) begin
        logic [6:0] rs;
        logic wr;
        logic [4:0] a;
        logic [7:0] wd;
        rs = ($urandom % 6 == 0) ? 7'(1 << ($urandom % 7)) : 7'd0;
        if ($urandom % 9 == 0) m = ~m;
        if ($urandom % 5 == 0) rd = ~rd;
        wr = 0; a = 5'h14; wd = 0;
        if (!rd && $urandom % 25 == 0) begin
          wr = 1; a = ($urandom % 2) ? 5'h15 : 5'h16; wd = 8'($urandom);
        end
        step(rs, m, wr, rd, a, wd);
        check(irqOut == mIrq, "R4 random irq", irqOut, mIrq);
        check(stbyIrqN == !(mStby && m), "R8 random stby", stbyIrqN, !(mStby && m));
        if (rd) check(busRdata == mStat, "R5 random status", busRdata, mStat);
      end
    end
    summary();
  end
endmodule